// File: doc/BRIEF.md
# Tone-Pair Audio Bit Demodulator with Timing Recovery

This block turns a stream of signed audio samples carrying a two-tone frequency-shift-keyed signal into a stream of decoded data bits. Each accepted sample is multiplied by the sample that arrived half a bit period earlier. The product is passed through a first-order recursive low-pass filter. The sign of the filtered value is a one-bit tone decision, taken once per sample, and these decisions are kept in a short history.

A phase counter advances a fixed step on every accepted sample. Its wrap marks the moment a bit is decided. Whenever the slicer history shows a clean change of tone, the counter is nudged one step toward centring the decision window. At each wrap a 2-of-3 majority vote over the newest tone decisions gives the channel bit. The channel bits are then NRZI-decoded: an unchanged level gives 1, a change gives 0. A one-cycle strobe marks each decoded bit. The block sits between a sample source that pulses a valid strobe at eight samples per bit and a frame parser that consumes the bit stream.

Top module: `afsk_delay_demod`

## Requirements
- R1: The discriminator product for an accepted sample s[n] is (s[n] * s[n-4]) arithmetically shifted right by 2. The four-deep delay line holds zeros after reset, so the first four products are zero.
- R2: The filter output is y[n] = x[n-1] + x[n] + (y[n-1] >>> 1), where x is the product of R1 and x[-1] = y[-1] = 0 after reset. The arithmetic is signed and does not overflow for any input, including -128 * -128.
- R3: Each accepted sample shifts one sliced value into the slicer history: 1 when y[n] > 0, 0 otherwise.
- R4: The 64-step phase counter starts at 0, adds 8 per accepted sample and wraps modulo 64. Each wrap (sum of 64 or more) produces one bit. With a signal that never causes a nudge, this is exactly one bit per 8 samples, the first on the 8th sample after reset.
- R5: A transition exists when history bits [1:0] both differ from bits [3:2] (bit 0 is the newest). On a transition, before the add of 8, the phase gains 1 if it is below 32 and loses 1 otherwise.
- R6: The channel bit produced at a wrap is 1 when at least two of history bits [2:0] are 1, using the history that includes the current sample.
- R7: The decoded output is 1 when the new channel bit equals the previous channel bit, and 0 otherwise. The previous channel bit is 0 after reset.
- R8: bit_vld is a one-cycle pulse. It rises in the second clock after the edge that accepts the wrapping sample, and bit_out is valid while bit_vld is high.
- R9: Reset clears the delay line, the filter, the history, the phase and the outputs. After reset the block behaves exactly as it did after the first reset.
- R10: sample_in is ignored in cycles where sample_vld is low. No state advances, and the decoded bit stream is the same as with back-to-back strobes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_vld | input | 1 | Strobe: sample_in is accepted this cycle |
| sample_in | input | 8 | Signed two's-complement audio sample |
| bit_vld | output | 1 | One-cycle strobe for a decoded bit |
| bit_out | output | 1 | NRZI-decoded data bit |

## Verification
A wrong delay-line, filter or history value shows up only through the slicer. The first effect at the ports is a changed majority bit, or a nudge that should not happen, which shifts a bit_vld pulse by a sample. This can take several bit periods to surface, so the bench compares bit_vld and bit_out on every clock against a behavioural model, using long tone sequences and full-scale random input. A phase-counter error shows within one bit period as a misplaced strobe. The silence test counts strobes exactly, so a single extra or missing step is caught.

// File: rtl/afsk_dm_pkg.sv
package afsk_dm_pkg;

   // Two consecutive pairs of sliced samples both differ: tone changed cleanly.
   function automatic logic pair_flip(input logic [3:0] h);
      return ((h[1:0] ^ h[3:2]) == 2'b11);
   endfunction

   // Majority over an odd-length window.
   function automatic logic vote_many(input logic [31:0] v, input int n);
      int ones;
      ones = 0;
      for (int i = 0; i < n; i++) begin
         ones += int'(v[i]);
      end
      return (ones > n / 2);
   endfunction

endpackage

// File: rtl/afsk_dm_delay.sv
module afsk_dm_delay #(
   parameter int SAMPLE_W = 8,
   parameter int DEPTH    = 4
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       shift_en,
   input  logic signed [SAMPLE_W-1:0] din,
   output logic signed [SAMPLE_W-1:0] tap
);
   logic signed [SAMPLE_W-1:0] stage_q [DEPTH];

   generate
      for (genvar i = 0; i < DEPTH; i++) begin : g_stage
         if (i == 0) begin : g_head
            always_ff @(posedge clk) begin
               if (!rst_n)        stage_q[0] <= '0;
               else if (shift_en) stage_q[0] <= din;
            end
         end else begin : g_body
            always_ff @(posedge clk) begin
               if (!rst_n)        stage_q[i] <= '0;
               else if (shift_en) stage_q[i] <= stage_q[i-1];
            end
         end
      end
   endgenerate

   // Oldest entry: sample accepted DEPTH strobes ago.
   assign tap = stage_q[DEPTH-1];

   p_hold_idle_r10 : assert property (@(posedge clk) disable iff (!rst_n)
      !shift_en |=> $stable(tap));
endmodule

// File: rtl/afsk_dm_discrim.sv
module afsk_dm_discrim #(
   parameter int SAMPLE_W   = 8,
   parameter int ACC_W      = 16,
   parameter int PROD_SHIFT = 2,
   parameter int FB_SHIFT   = 1,
   parameter int HIST_W     = 4
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       sample_vld,
   input  logic signed [SAMPLE_W-1:0] sample_in,
   input  logic signed [SAMPLE_W-1:0] delayed,
   output logic                       slice_vld,
   output logic [HIST_W-1:0]          hist
);
   localparam int PROD_W  = 2 * SAMPLE_W;
   localparam int X_MAG   = 1 << (PROD_W - 2 - PROD_SHIFT);
   localparam int Y_BOUND = 4 * X_MAG;

   logic signed [PROD_W-1:0] prod_full;
   logic signed [PROD_W-1:0] prod_sh;
   logic signed [ACC_W-1:0]  x_now;
   logic signed [ACC_W-1:0]  x_last_q;
   logic signed [ACC_W-1:0]  y_q;
   logic signed [ACC_W-1:0]  y_next;
   logic                     slice_bit;
   logic                     slice_vld_q;
   logic [HIST_W-1:0]        hist_q;

   always_comb begin
      prod_full = PROD_W'(delayed) * PROD_W'(sample_in);
      prod_sh   = prod_full >>> PROD_SHIFT;
      x_now     = ACC_W'(prod_sh);
      y_next    = x_last_q + x_now + (y_q >>> FB_SHIFT);
      slice_bit = !y_next[ACC_W-1] && (y_next != '0);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         x_last_q    <= '0;
         y_q         <= '0;
         hist_q      <= '0;
         slice_vld_q <= 1'b0;
      end else begin
         slice_vld_q <= sample_vld;
         if (sample_vld) begin
            x_last_q <= x_now;
            y_q      <= y_next;
            hist_q   <= {hist_q[HIST_W-2:0], slice_bit};
         end
      end
   end

   assign slice_vld = slice_vld_q;
   assign hist      = hist_q;

   p_no_overflow_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      (int'(y_q) <= Y_BOUND) && (int'(y_q) >= -Y_BOUND));

   p_hist_shift_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      sample_vld |=> (hist_q[HIST_W-1:1] == $past(hist_q[HIST_W-2:0])));
endmodule

// File: rtl/afsk_dm_clkrec.sv
module afsk_dm_clkrec #(
   parameter int PHASE_MAX = 64,
   parameter int STEP      = 8,
   parameter int NUDGE     = 1,
   parameter int VOTE_N    = 3,
   parameter int HIST_W    = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              slice_vld,
   input  logic [HIST_W-1:0] hist,
   output logic              bit_tick,
   output logic              raw_bit
);
   import afsk_dm_pkg::*;

   localparam int PH_W   = $clog2(PHASE_MAX + STEP + NUDGE) + 1;
   localparam int THRESH = PHASE_MAX / 2;

   logic [PH_W-1:0] phase_q;
   logic [PH_W-1:0] ph_adj;
   logic [PH_W-1:0] ph_sum;
   logic            flip;
   logic            wrap;
   logic            vote;

   generate
      if (VOTE_N == 3) begin : g_vote3
         assign vote = (hist[0] & hist[1]) | (hist[0] & hist[2]) | (hist[1] & hist[2]);
      end else begin : g_voten
         logic [31:0] win;
         always_comb begin
            win = '0;
            win[VOTE_N-1:0] = hist[VOTE_N-1:0];
         end
         assign vote = vote_many(win, VOTE_N);
      end
   endgenerate

   always_comb begin
      flip = pair_flip(hist[3:0]);
      if (!flip)
         ph_adj = phase_q;
      else if (phase_q < PH_W'(THRESH))
         ph_adj = phase_q + PH_W'(NUDGE);
      else
         ph_adj = phase_q - PH_W'(NUDGE);
      ph_sum = ph_adj + PH_W'(STEP);
      wrap   = (ph_sum >= PH_W'(PHASE_MAX));
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         phase_q <= '0;
      else if (slice_vld)
         phase_q <= wrap ? (ph_sum - PH_W'(PHASE_MAX)) : ph_sum;
   end

   assign bit_tick = slice_vld & wrap;
   assign raw_bit  = vote;

   p_phase_range_r4 : assert property (@(posedge clk) disable iff (!rst_n)
      phase_q < PH_W'(PHASE_MAX));

   p_phase_idle_r10 : assert property (@(posedge clk) disable iff (!rst_n)
      !slice_vld |=> $stable(phase_q));
endmodule

// File: rtl/afsk_dm_nrzi.sv
module afsk_dm_nrzi (
   input  logic clk,
   input  logic rst_n,
   input  logic bit_tick,
   input  logic raw_bit,
   output logic bit_vld,
   output logic bit_out
);
   logic prev_q;
   logic vld_q;
   logic out_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev_q <= 1'b0;
         vld_q  <= 1'b0;
         out_q  <= 1'b0;
      end else begin
         vld_q <= bit_tick;
         if (bit_tick) begin
            prev_q <= raw_bit;
            out_q  <= (raw_bit == prev_q);
         end
      end
   end

   assign bit_vld = vld_q;
   assign bit_out = out_q;

   p_out_held_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      !bit_tick |=> $stable(out_q));
endmodule

// File: rtl/afsk_delay_demod.sv
module afsk_delay_demod #(
   parameter int SAMPLE_W        = 8,
   parameter int SAMPLES_PER_BIT = 8,
   parameter int PHASE_STEP      = 8,
   parameter int NUDGE           = 1,
   parameter int ACC_W           = 16,
   parameter int PROD_SHIFT      = 2,
   parameter int FB_SHIFT        = 1,
   parameter int VOTE_N          = 3
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       sample_vld,
   input  logic signed [SAMPLE_W-1:0] sample_in,
   output logic                       bit_vld,
   output logic                       bit_out
);
   localparam int DELAY     = SAMPLES_PER_BIT / 2;
   localparam int PHASE_MAX = SAMPLES_PER_BIT * PHASE_STEP;
   localparam int HIST_W    = (VOTE_N > 4) ? VOTE_N : 4;

   generate
      if (SAMPLES_PER_BIT < 2 || (SAMPLES_PER_BIT % 2) != 0) begin : g_bad_spb
         $error("samples per bit must be even and at least 2");
      end
      if (ACC_W < 2 * SAMPLE_W) begin : g_bad_acc
         $error("accumulator narrower than the product");
      end
      if ((VOTE_N % 2) == 0 || VOTE_N > SAMPLES_PER_BIT || VOTE_N > 32) begin : g_bad_vote
         $error("vote window must be odd and fit in one bit period");
      end
      if (NUDGE < 1 || NUDGE >= PHASE_STEP) begin : g_bad_nudge
         $error("nudge must be smaller than the phase step");
      end
   endgenerate

   logic signed [SAMPLE_W-1:0] tap;
   logic                       slice_vld;
   logic [HIST_W-1:0]          hist;
   logic                       bit_tick;
   logic                       raw_bit;

   afsk_dm_delay #(.SAMPLE_W(SAMPLE_W), .DEPTH(DELAY)) u_delay (
      .clk(clk), .rst_n(rst_n), .shift_en(sample_vld),
      .din(sample_in), .tap(tap));

   afsk_dm_discrim #(.SAMPLE_W(SAMPLE_W), .ACC_W(ACC_W), .PROD_SHIFT(PROD_SHIFT),
                     .FB_SHIFT(FB_SHIFT), .HIST_W(HIST_W)) u_discrim (
      .clk(clk), .rst_n(rst_n), .sample_vld(sample_vld), .sample_in(sample_in),
      .delayed(tap), .slice_vld(slice_vld), .hist(hist));

   afsk_dm_clkrec #(.PHASE_MAX(PHASE_MAX), .STEP(PHASE_STEP), .NUDGE(NUDGE),
                    .VOTE_N(VOTE_N), .HIST_W(HIST_W)) u_clkrec (
      .clk(clk), .rst_n(rst_n), .slice_vld(slice_vld), .hist(hist),
      .bit_tick(bit_tick), .raw_bit(raw_bit));

   afsk_dm_nrzi u_nrzi (
      .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .raw_bit(raw_bit),
      .bit_vld(bit_vld), .bit_out(bit_out));

   p_strobe_origin_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      bit_vld |-> $past(slice_vld));

   p_single_pulse_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      bit_vld |=> !bit_vld);
endmodule

// File: tb/afsk_delay_demod_bench.sv
module afsk_delay_demod_bench;
   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              sample_vld = 1'b0;
   logic signed [7:0] sample_in = '0;
   logic              bit_vld;
   logic              bit_out;

   always #4 clk = ~clk;

   afsk_delay_demod u_afsk_delay_demod (
      .clk(clk), .rst_n(rst_n), .sample_vld(sample_vld), .sample_in(sample_in),
      .bit_vld(bit_vld), .bit_out(bit_out));

   int    n_cmp = 0;
   int    n_bad = 0;
   string tag = "R9";
   int    bits_seen = 0;

   // behavioural reference state
   int dq[$];
   int m_xl, m_y, m_h, m_ph, m_a;
   bit e0_v, e0_b, e1_v, e1_b;

   task automatic model_reset();
      dq.delete();
      for (int i = 0; i < 4; i++) dq.push_back(0);
      m_xl = 0; m_y = 0; m_h = 0; m_ph = 0; m_a = 0;
      e0_v = 0; e0_b = 0; e1_v = 0; e1_b = 0;
   endtask

   task automatic model_sample(input int s, output bit v, output bit b);
      int d, x, yn, p, ones, nb;
      d = dq.pop_front();
      dq.push_back(s);
      x = (d * s) >>> 2;
      yn = m_xl + x + (m_y >>> 1);
      m_xl = x; m_y = yn;
      m_h = ((m_h << 1) | ((yn > 0) ? 1 : 0)) & 15;
      p = m_ph;
      if ((((m_h ^ (m_h >> 2)) & 3) == 3)) p = (p < 32) ? p + 1 : p - 1;
      p = p + 8;
      v = 0; b = 0;
      if (p >= 64) begin
         p = p - 64;
         ones = (m_h & 1) + ((m_h >> 1) & 1) + ((m_h >> 2) & 1);
         nb = (ones >= 2) ? 1 : 0;
         b = (nb == (m_a & 1));
         m_a = nb;
         v = 1;
      end
      m_ph = p;
   endtask

   task automatic step(input bit vld, input int s);
      bit nv, nb;
      @(negedge clk);
      n_cmp++;
      if (bit_vld !== e0_v || (e0_v && bit_out !== e0_b)) begin
         n_bad++;
         $display("FAIL %s: bit_vld/bit_out actual %b/%b expected %b/%b at %0t",
                  tag, bit_vld, bit_out, e0_v, e0_b, $time);
      end
      if (bit_vld === 1'b1) bits_seen++;
      e0_v = e1_v; e0_b = e1_b;
      sample_vld = vld;
      sample_in  = 8'(s);
      nv = 0; nb = 0;
      if (vld && rst_n) model_sample(s, nv, nb);
      e1_v = nv; e1_b = nb;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; sample_vld = 1'b0;
      repeat (3) @(negedge clk);
      model_reset();
      rst_n = 1'b1;
   endtask

   task automatic check_count(input string t, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: bit count actual %0d expected %0d", t, act, exp);
      end
   endtask

   // tone generator: mark 1200 Hz, space 2200 Hz at 9600 samples/s
   real tph = 0.0;
   real bpos = 0.0;
   bit  tone_space = 0;

   function automatic int tone_sample(input real spb);
      real f;
      int  v;
      f = tone_space ? 2200.0 : 1200.0;
      tph = tph + 2.0 * 3.14159265358979 * f / 9600.0;
      if (tph > 6.28318530717959) tph = tph - 6.28318530717959;
      bpos = bpos + 1.0;
      if (bpos >= spb) begin
         bpos = bpos - spb;
         if ($urandom_range(0, 1) == 0) tone_space = ~tone_space;
      end
      v = $rtoi(100.0 * $sin(tph));
      return v;
   endfunction

   int cyc = 0;
   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         n_bad++;
         $display("FAIL watchdog: cycles actual %0d expected below 150000", cyc);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      model_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R9: idle after reset, no strobes
      tag = "R9";
      for (int i = 0; i < 10; i++) step(0, 0);

      // R4/R7: silence, exactly one bit per 8 samples, all decoded 1
      tag = "R4/R7";
      bits_seen = 0;
      for (int i = 0; i < 80; i++) step(1, 0);
      step(0, 0); step(0, 0);
      check_count("R4", bits_seen, 10);

      // R1/R2/R3/R8: clean tones, back-to-back strobes
      tag = "R1/R2/R3/R8";
      for (int i = 0; i < 1200; i++) step(1, tone_sample(8.0));

      // R5/R6: bit period drifts from the nominal, nudges needed
      tag = "R5/R6";
      for (int i = 0; i < 1500; i++) step(1, tone_sample(8.3));
      for (int i = 0; i < 1500; i++) step(1, tone_sample(7.7));

      // R10: gaps between strobes with junk on sample_in
      tag = "R10";
      for (int i = 0; i < 600; i++) begin
         step(1, tone_sample(8.0));
         for (int g = 0; g < 3; g++) step(0, int'($urandom_range(0, 255)) - 128);
      end

      // R6/R2: full-scale random samples including -128
      tag = "R6/R2";
      for (int i = 0; i < 1500; i++) begin
         int r;
         r = (i % 7 == 0) ? -128 : int'($urandom_range(0, 255)) - 128;
         step(1, r);
      end
      for (int i = 0; i < 200; i++) step(1, -128);

      // R9: second reset, then the silence count must repeat exactly
      tag = "R9";
      do_reset();
      bits_seen = 0;
      for (int i = 0; i < 80; i++) step(1, 0);
      step(0, 0); step(0, 0);
      check_count("R9", bits_seen, 10);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule